// File: doc/BRIEF.md
# Host memory-window access port

This block is a host-side slave that gives a narrow 16-bit register interface access to a 32-bit-addressed internal memory space. The host loads a window address in two halves, then moves data through data registers. Each data access is turned into a single memory-side strobe with a write enable and half-word lane enables. The memory answers a read in the cycle after the strobe, and the block forwards that answer to the host with a valid flag in the same cycle.

The same memory can be viewed in two ways. In the data view, the address is used unchanged, and each 16-bit word occupies the low lane of the memory bus. In the instruction view, the host address counts 32-bit instruction words. The block maps it into the window by scaling it by four and setting a flag bit. An instruction moves as two halves: the low-half register first, then the high-half register. A separate read-and-clear register returns a data word and zeroes it. An optional auto-increment lets a stream of accesses walk through memory without the address being reloaded.

Top module: `memwin_port`

## Requirements
- R1: After reset, mem_req and host_rvalid are low, and reads of the address-low (offset 0), address-high (offset 1) and control (offset 2) registers return 0.
- R2: A write to offset 0 loads address bits 15:0 and a write to offset 1 loads bits 31:16; both halves read back what was written.
- R3: With control bit 1 clear, a read or write of offset 4 issues exactly one strobe with mem_be = 01 at the unchanged address, with data on mem_wdata[15:0]; a read returns mem_rdata[15:0] with host_rvalid high in the cycle after the strobe.
- R4: With control bit 1 set (instruction view), every instruction strobe uses window address (N << 2) with bit 22 set, where N is the address register.
- R5: In the instruction view, a write to offset 5 only buffers the low half and issues no strobe; the following write to offset 4 issues one strobe with mem_be = 11 and mem_wdata = {high, low}.
- R6: In the instruction view, a read of offset 5 issues one strobe with mem_be = 11 and returns the low half; the next read of offset 4 returns the high half of that word without a strobe.
- R7: With control bit 0 set, each data-view access and each read-and-clear advances the address register by one.
- R8: With control bit 0 set, an instruction access advances the address register by one only when the high half (offset 4) completes; the low-half access leaves it unchanged.
- R9: With control bit 0 clear, data accesses leave the address register unchanged.
- R10: A read of offset 6 issues a read strobe with mem_be = 01 and, in the next cycle, a write strobe of zero to the same address and lane; it returns the old word. It always uses the data view.
- R11: A write to offset 0, 1 or 2 cancels a pending low/high pair. A later offset-4 write then issues mem_be = 10 carrying only the high half, and a later offset-4 read issues its own strobe with mem_be = 10 and returns mem_rdata[31:16].
- R12: In the data view, offset 5 is ignored: writes issue no strobe and reads return 0. Writes to offset 6 and all accesses to offsets 3 and 7 issue no strobe, and reads of them return 0.
- R13: mem_req lasts a single cycle, except that the read strobe of a read-and-clear is followed at once by its clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle host register write |
| host_rd | input | 1 | One-cycle host register read |
| host_off | input | 3 | Register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, two cycles after host_rd |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Strobe is a write |
| mem_be | output | 2 | Half-word lane enables (bit 0 low half, bit 1 high half) |
| mem_addr | output | 32 | Window address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read strobe |

## Verification
The assertions assume the host pulses host_wr or host_rd for one cycle at a time, never both at once, and leaves at least three idle cycles between accesses. A read-and-clear's follow-up write and any read's return cycle therefore never overlap the next access. The single-cycle strobe and zero-write checks rely on that spacing. The directed tasks drive every access through one read task and one write task, which each occupy four cycles, so the stimulus always keeps this distance. The memory model answers reads one cycle after the strobe and honours the lane enables on writes.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_ADDR_LO = 3'd0;
  localparam logic [OFF_W-1:0] OFF_ADDR_HI = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL    = 3'd2;
  localparam logic [OFF_W-1:0] OFF_DATA    = 3'd4;
  localparam logic [OFF_W-1:0] OFF_ILO     = 3'd5;
  localparam logic [OFF_W-1:0] OFF_RCLR    = 3'd6;

  localparam int CTRL_AUTOINC = 0;
  localparam int CTRL_INSTR   = 1;

  typedef enum logic [1:0] {SRC_SNAP, SRC_MEM_LO, SRC_MEM_HI, SRC_MEM_PAIR} rd_src_e;
  typedef enum logic [2:0] {SNAP_ZERO, SNAP_ALO, SNAP_AHI, SNAP_CTRL, SNAP_HOLD} snap_sel_e;

  typedef struct packed {
    logic      ld_lo;
    logic      ld_hi;
    logic      ld_ctrl;
    logic      strobe;
    logic      we;
    logic [1:0] be;
    logic      clr;
    logic      instr_addr;
    logic      step;
    logic      pair_set;
    logic      pair_clr;
    logic      buf_lo;
    logic      rd_en;
    rd_src_e   src;
    snap_sel_e snap;
  } dec_t;
endpackage

// File: rtl/memwin_decode.sv
module memwin_decode
  import memwin_pkg::*;
(
  input  logic             wr,
  input  logic             rd,
  input  logic [OFF_W-1:0] off,
  input  logic             instr_mode,
  input  logic             pair_pend,
  output dec_t             dec
);
  always_comb begin
    dec       = '0;
    dec.src   = SRC_SNAP;
    dec.snap  = SNAP_ZERO;
    dec.rd_en = rd && !wr;
    if (wr || rd) begin
      case (off)
        OFF_ADDR_LO: begin dec.ld_lo = wr;   dec.snap = SNAP_ALO;  end
        OFF_ADDR_HI: begin dec.ld_hi = wr;   dec.snap = SNAP_AHI;  end
        OFF_CTRL:    begin dec.ld_ctrl = wr; dec.snap = SNAP_CTRL; end
        OFF_DATA: begin
          dec.step = 1'b1;
          if (!instr_mode) begin
            dec.strobe = 1'b1;
            dec.we     = wr;
            dec.be     = 2'b01;
            dec.src    = SRC_MEM_LO;
          end else if (wr) begin
            dec.strobe     = 1'b1;
            dec.we         = 1'b1;
            dec.be         = pair_pend ? 2'b11 : 2'b10;
            dec.instr_addr = 1'b1;
            dec.pair_clr   = 1'b1;
          end else if (pair_pend) begin
            dec.snap     = SNAP_HOLD;
            dec.pair_clr = 1'b1;
          end else begin
            dec.strobe     = 1'b1;
            dec.be         = 2'b10;
            dec.instr_addr = 1'b1;
            dec.src        = SRC_MEM_HI;
          end
        end
        OFF_ILO: begin
          if (instr_mode) begin
            dec.pair_set = 1'b1;
            if (wr) begin
              dec.buf_lo = 1'b1;
            end else begin
              dec.strobe     = 1'b1;
              dec.be         = 2'b11;
              dec.instr_addr = 1'b1;
              dec.src        = SRC_MEM_PAIR;
            end
          end
        end
        OFF_RCLR: begin
          if (rd && !wr) begin
            dec.strobe = 1'b1;
            dec.be     = 2'b01;
            dec.clr    = 1'b1;
            dec.step   = 1'b1;
            dec.src    = SRC_MEM_LO;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/memwin_addr.sv
module memwin_addr
  import memwin_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int FLAG_BIT = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic                ld_ctrl,
  input  logic                step,
  input  logic                instr_view,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] addr_q,
  output logic [2*HALF_W-1:0] win_addr,
  output logic                autoinc,
  output logic                instr_mode,
  output logic                advance
);
  localparam int ADDR_W = 2 * HALF_W;

  function automatic logic [ADDR_W-1:0] instr_window(input logic [ADDR_W-1:0] n);
    return (n << 2) | (ADDR_W'(1) << FLAG_BIT);
  endfunction

  assign advance  = step && autoinc;
  assign win_addr = instr_view ? instr_window(addr_q) : addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      autoinc    <= 1'b0;
      instr_mode <= 1'b0;
    end else begin
      if (ld_lo)        addr_q[HALF_W-1:0]      <= wdata;
      else if (ld_hi)   addr_q[ADDR_W-1:HALF_W] <= wdata;
      else if (advance) addr_q                  <= addr_q + ADDR_W'(1);
      if (ld_ctrl) begin
        autoinc    <= wdata[CTRL_AUTOINC];
        instr_mode <= wdata[CTRL_INSTR];
      end
    end
  end
endmodule

// File: rtl/memwin_pair.sv
module memwin_pair #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_set,
  input  logic              pair_clr,
  input  logic              cancel,
  input  logic              buf_lo,
  input  logic              cap_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic [HALF_W-1:0] rhi,
  output logic              pair_pend,
  output logic [HALF_W-1:0] lo_buf,
  output logic [HALF_W-1:0] hi_hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_pend <= 1'b0;
      lo_buf    <= '0;
      hi_hold   <= '0;
    end else begin
      if (cancel || pair_clr) pair_pend <= 1'b0;
      else if (pair_set)      pair_pend <= 1'b1;
      if (buf_lo) lo_buf  <= wdata;
      if (cap_hi) hi_hold <= rhi;
    end
  end
endmodule

// File: rtl/memwin_seq.sv
module memwin_seq
  import memwin_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                we,
  input  logic [1:0]          be,
  input  logic                clr,
  input  logic [2*HALF_W-1:0] win_addr,
  input  logic [2*HALF_W-1:0] wdata,
  input  logic                rd_en,
  input  rd_src_e             src,
  input  logic [HALF_W-1:0]   snap_val,
  input  logic [2*HALF_W-1:0] mem_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [1:0]          mem_be,
  output logic [2*HALF_W-1:0] mem_addr,
  output logic [2*HALF_W-1:0] mem_wdata,
  output logic                clr_follow,
  output logic                host_rvalid,
  output logic [HALF_W-1:0]   host_rdata,
  output logic                cap_hi
);
  localparam int MEM_W = 2 * HALF_W;

  logic        rd1;
  rd_src_e     src1, src2;
  logic [HALF_W-1:0] snap1, snap2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_be     <= '0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      clr_follow <= 1'b0;
    end else if (strobe) begin
      mem_req    <= 1'b1;
      mem_we     <= we;
      mem_be     <= be;
      mem_addr   <= win_addr;
      mem_wdata  <= wdata;
      clr_follow <= clr;
    end else if (clr_follow) begin
      mem_req    <= 1'b1;
      mem_we     <= 1'b1;
      mem_be     <= 2'b01;
      mem_wdata  <= '0;
      clr_follow <= 1'b0;
    end else begin
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      clr_follow <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd1         <= 1'b0;
      host_rvalid <= 1'b0;
      src1        <= SRC_SNAP;
      src2        <= SRC_SNAP;
      snap1       <= '0;
      snap2       <= '0;
    end else begin
      rd1         <= rd_en;
      src1        <= src;
      snap1       <= snap_val;
      host_rvalid <= rd1;
      src2        <= src1;
      snap2       <= snap1;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_rvalid) begin
      case (src2)
        SRC_SNAP:   host_rdata = snap2;
        SRC_MEM_HI: host_rdata = mem_rdata[MEM_W-1:HALF_W];
        default:    host_rdata = mem_rdata[HALF_W-1:0];
      endcase
    end
  end

  assign cap_hi = host_rvalid && (src2 == SRC_MEM_PAIR);
endmodule

// File: rtl/memwin_port.sv
module memwin_port
  import memwin_pkg::*;
#(
  parameter int HALF_W         = 16,
  parameter int INSTR_FLAG_BIT = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [OFF_W-1:0]    host_off,
  input  logic [HALF_W-1:0]   host_wdata,
  output logic [HALF_W-1:0]   host_rdata,
  output logic                host_rvalid,
  output logic                mem_req,
  output logic                mem_we,
  output logic [1:0]          mem_be,
  output logic [2*HALF_W-1:0] mem_addr,
  output logic [2*HALF_W-1:0] mem_wdata,
  input  logic [2*HALF_W-1:0] mem_rdata
);
  localparam int ADDR_W = 2 * HALF_W;
  localparam int MEM_W  = 2 * HALF_W;

  dec_t              dec;
  logic [ADDR_W-1:0] addr_q, win_addr;
  logic              autoinc, instr_mode, advance;
  logic              pair_pend, cap_hi, clr_follow, cancel;
  logic [HALF_W-1:0] lo_buf, hi_hold, snap_val;
  logic [MEM_W-1:0]  strobe_wdata;

  memwin_decode u_dec (
    .wr(host_wr), .rd(host_rd), .off(host_off),
    .instr_mode(instr_mode), .pair_pend(pair_pend), .dec(dec)
  );

  memwin_addr #(.HALF_W(HALF_W), .FLAG_BIT(INSTR_FLAG_BIT)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .ld_lo(dec.ld_lo), .ld_hi(dec.ld_hi), .ld_ctrl(dec.ld_ctrl),
    .step(dec.step), .instr_view(dec.instr_addr), .wdata(host_wdata),
    .addr_q(addr_q), .win_addr(win_addr),
    .autoinc(autoinc), .instr_mode(instr_mode), .advance(advance)
  );

  assign cancel = dec.ld_lo || dec.ld_hi || dec.ld_ctrl;

  memwin_pair #(.HALF_W(HALF_W)) u_pair (
    .clk(clk), .rst_n(rst_n),
    .pair_set(dec.pair_set), .pair_clr(dec.pair_clr), .cancel(cancel),
    .buf_lo(dec.buf_lo), .cap_hi(cap_hi), .wdata(host_wdata),
    .rhi(mem_rdata[MEM_W-1:HALF_W]),
    .pair_pend(pair_pend), .lo_buf(lo_buf), .hi_hold(hi_hold)
  );

  always_comb begin
    strobe_wdata = '0;
    if (dec.we) begin
      case (dec.be)
        2'b11:   strobe_wdata = {host_wdata, lo_buf};
        2'b10:   strobe_wdata = {host_wdata, {HALF_W{1'b0}}};
        default: strobe_wdata = {{HALF_W{1'b0}}, host_wdata};
      endcase
    end
  end

  always_comb begin
    case (dec.snap)
      SNAP_ALO:  snap_val = addr_q[HALF_W-1:0];
      SNAP_AHI:  snap_val = addr_q[ADDR_W-1:HALF_W];
      SNAP_CTRL: snap_val = HALF_W'({instr_mode, autoinc});
      SNAP_HOLD: snap_val = hi_hold;
      default:   snap_val = '0;
    endcase
  end

  memwin_seq #(.HALF_W(HALF_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .strobe(dec.strobe), .we(dec.we), .be(dec.be), .clr(dec.clr),
    .win_addr(win_addr), .wdata(strobe_wdata),
    .rd_en(dec.rd_en), .src(dec.src), .snap_val(snap_val),
    .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .clr_follow(clr_follow), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .cap_hi(cap_hi)
  );
endmodule

// File: rtl/memwin_port_chk.sv
module memwin_port_chk
  import memwin_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int FLAG_BIT = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_wr,
  input logic [OFF_W-1:0]    host_off,
  input logic                host_rvalid,
  input logic                mem_req,
  input logic                mem_we,
  input logic [1:0]          mem_be,
  input logic [2*HALF_W-1:0] mem_addr,
  input logic [2*HALF_W-1:0] mem_wdata,
  input logic                clr_follow,
  input logic                pair_pend,
  input logic                autoinc,
  input logic [2*HALF_W-1:0] addr_q
);
  logic addr_wr;
  assign addr_wr = host_wr && (host_off == OFF_ADDR_LO || host_off == OFF_ADDR_HI);

  AST_INSTR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_be[1] |-> mem_addr[FLAG_BIT] && mem_addr[1:0] == 2'b00); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !clr_follow |=> !mem_req); // R13
  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && clr_follow |=> mem_req && mem_we && mem_be == 2'b01 && mem_wdata == '0 && $stable(mem_addr)); // R10
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> host_rvalid); // R3
  AST_LANES_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_be != 2'b00); // R3
  AST_PAIR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && (host_off == OFF_ADDR_LO || host_off == OFF_ADDR_HI || host_off == OFF_CTRL) |=> !pair_pend); // R11
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !autoinc && !addr_wr |=> $stable(addr_q)); // R9
  AST_LOW_HALF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_off == OFF_ILO |=> !mem_req); // R5
endmodule

bind memwin_port memwin_port_chk #(.HALF_W(HALF_W), .FLAG_BIT(INSTR_FLAG_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_off(host_off),
  .host_rvalid(host_rvalid), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .clr_follow(clr_follow),
  .pair_pend(pair_pend), .autoinc(autoinc), .addr_q(addr_q)
);

// File: tb/memwin_port_bench.sv
module memwin_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_off = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic        mem_req, mem_we;
  logic [1:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  memwin_port u_memwin_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mem_req(mem_req), .mem_we(mem_we),
    .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // memory model and strobe log
  logic [31:0] mem [logic [31:0]];
  int          strobes = 0;
  logic [31:0] l_addr = '0, l_wdata = '0;
  logic [1:0]  l_be = '0;
  logic        l_we = 1'b0;
  logic        pl_go = 1'b0;
  logic [31:0] pl_addr = '0, pl_data = '0;

  always @(posedge clk) begin
    logic [31:0] cur;
    if (pl_go) mem[pl_addr] = pl_data;
    if (mem_req) begin
      strobes++;
      l_addr = mem_addr; l_be = mem_be; l_we = mem_we; l_wdata = mem_wdata;
      cur = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      if (mem_we) begin
        if (mem_be[0]) cur[15:0]  = mem_wdata[15:0];
        if (mem_be[1]) cur[31:16] = mem_wdata[31:16];
        mem[mem_addr] = cur;
      end else begin
        mem_rdata <= cur;
      end
    end
  end

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  int total = 0, fails = 0;
  bit done = 0;
  logic req_n1, req_n2;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk); pl_addr = a; pl_data = v; pl_go = 1'b1;
    @(negedge clk); pl_go = 1'b0;
  endtask

  task automatic host_write(input logic [2:0] off, input logic [15:0] d);
    @(negedge clk); host_wr = 1'b1; host_off = off; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic host_read(input logic [2:0] off, output logic [15:0] d, output logic vld);
    @(negedge clk); host_rd = 1'b1; host_off = off;
    @(negedge clk); host_rd = 1'b0; req_n1 = mem_req;
    @(negedge clk); vld = host_rvalid; d = host_rdata; req_n2 = mem_req;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] off, input logic [15:0] exp);
    logic [15:0] d; logic v;
    host_read(off, d, v);
    chk({tag, " rvalid"}, 32'(v), 32'd1);
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 host_rvalid", 32'(host_rvalid), 0);
    rd_chk("R1 addr lo", 3'd0, 16'h0);
    rd_chk("R1 addr hi", 3'd1, 16'h0);
    rd_chk("R1 ctrl", 3'd2, 16'h0);
  endtask

  task automatic t_addr_load;
    host_write(3'd0, 16'h1234);
    host_write(3'd1, 16'h0005);
    rd_chk("R2 addr lo", 3'd0, 16'h1234);
    rd_chk("R2 addr hi", 3'd1, 16'h0005);
  endtask

  task automatic t_data_access;
    int s0;
    preload(32'h0005_1234, 32'hAAAA_BEEF);
    s0 = strobes;
    rd_chk("R3 data read", 3'd4, 16'hBEEF);
    chk("R3 strobe count", strobes, s0 + 1);
    chk("R3 lanes", 32'(l_be), 32'h1);
    chk("R3 address", l_addr, 32'h0005_1234);
    chk("R13 strobe high", 32'(req_n1), 1);
    chk("R13 strobe one cycle", 32'(req_n2), 0);
    host_write(3'd4, 16'h5555);
    chk("R3 data write", peek(32'h0005_1234), 32'hAAAA_5555);
    chk("R9 address held", 32'(u_memwin_port.mem_addr), 32'h0005_1234);
    rd_chk("R9 addr lo unchanged", 3'd0, 16'h1234);
  endtask

  task automatic t_autoinc_data;
    host_write(3'd2, 16'h0001);
    host_write(3'd0, 16'h0100);
    host_write(3'd1, 16'h0000);
    host_write(3'd4, 16'h0011);
    host_write(3'd4, 16'h0022);
    host_write(3'd4, 16'h0033);
    chk("R7 word 0", peek(32'h100), 32'h11);
    chk("R7 word 1", peek(32'h101), 32'h22);
    chk("R7 word 2", peek(32'h102), 32'h33);
    rd_chk("R7 addr after stream", 3'd0, 16'h0103);
  endtask

  task automatic t_instr_write;
    int s0;
    host_write(3'd2, 16'h0003);
    host_write(3'd0, 16'h0010);
    host_write(3'd1, 16'h0000);
    s0 = strobes;
    host_write(3'd5, 16'h1111);
    chk("R5 low half no strobe", strobes, s0);
    rd_chk("R8 no step on low half", 3'd0, 16'h0010);
    host_write(3'd4, 16'h2222);
    chk("R5 one strobe", strobes, s0 + 1);
    chk("R5 lanes", 32'(l_be), 32'h3);
    chk("R4 window address", l_addr, 32'h0040_0040);
    chk("R5 word written", peek(32'h0040_0040), 32'h2222_1111);
    rd_chk("R8 step after high half", 3'd0, 16'h0011);
  endtask

  task automatic t_instr_read;
    int s0;
    preload(32'h0040_0044, 32'hCAFE_F00D);
    s0 = strobes;
    rd_chk("R6 low half", 3'd5, 16'hF00D);
    chk("R6 low strobe", strobes, s0 + 1);
    chk("R6 lanes", 32'(l_be), 32'h3);
    rd_chk("R6 high half", 3'd4, 16'hCAFE);
    chk("R6 no second strobe", strobes, s0 + 1);
    rd_chk("R8 step after read pair", 3'd0, 16'h0012);
  endtask

  task automatic t_cancel;
    int s0;
    host_write(3'd2, 16'h0002);
    host_write(3'd0, 16'h0020);
    host_write(3'd1, 16'h0000);
    preload(32'h0040_0080, 32'h1234_5678);
    host_write(3'd5, 16'h9999);
    host_write(3'd0, 16'h0020);
    host_write(3'd4, 16'hABCD);
    chk("R11 write lanes after cancel", 32'(l_be), 32'h2);
    chk("R11 high only written", peek(32'h0040_0080), 32'hABCD_5678);
    s0 = strobes;
    rd_chk("R11 low read", 3'd5, 16'h5678);
    host_write(3'd2, 16'h0002);
    rd_chk("R11 high read after cancel", 3'd4, 16'hABCD);
    chk("R11 high read strobes", strobes, s0 + 2);
    chk("R11 high read lanes", 32'(l_be), 32'h2);
  endtask

  task automatic t_rclr;
    int s0;
    host_write(3'd2, 16'h0001);
    host_write(3'd0, 16'h0200);
    host_write(3'd1, 16'h0000);
    preload(32'h200, 32'h7777_4321);
    s0 = strobes;
    rd_chk("R10 returns old", 3'd6, 16'h4321);
    chk("R10 two strobes", strobes, s0 + 2);
    chk("R10 clearing write", 32'(l_we), 1);
    chk("R10 clear lanes", 32'(l_be), 32'h1);
    chk("R10 cleared", peek(32'h200), 32'h7777_0000);
    rd_chk("R7 step after clear", 3'd0, 16'h0201);
  endtask

  task automatic t_ignored;
    int s0;
    host_write(3'd2, 16'h0000);
    s0 = strobes;
    rd_chk("R12 low reg data view", 3'd5, 16'h0000);
    host_write(3'd5, 16'hFFFF);
    host_write(3'd6, 16'hFFFF);
    rd_chk("R12 unmapped offset 7", 3'd7, 16'h0000);
    rd_chk("R12 unmapped offset 3", 3'd3, 16'h0000);
    chk("R12 no strobes", strobes, s0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_addr_load;
    t_data_access;
    t_autoinc_data;
    t_instr_write;
    t_instr_read;
    t_cancel;
    t_rclr;
    t_ignored;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule